// File: doc/BRIEF.md
# Permutation-Indexed Four-Lane Switch Chain

This block is a chain of identical routing stages, each of which carries four single-bit lanes through to four outputs. Every stage takes its own 5-bit code. The code picks one of the 24 orderings of four elements. A decoder turns the code into four 2-bit source selects, and four 4:1 multiplexers route the lanes with those selects. The chain length is a parameter. Stage 1 takes the 5 least significant challenge bits, and each later stage takes the next 5 bits.

In use, the system fans one launch edge out to all four lanes of the first stage. The challenge then sets which physical path each edge takes through the chain. The four lane inputs are separate ports, so the routing can be observed with distinct values on each lane. The block is logic only: it holds no state and uses no clock.

Top module: `perm_chain`

## Requirements
- R1: For every code value, the four outputs of a stage take their values from four distinct inputs. A one-hot lane pattern therefore leaves the chain one-hot, and the number of set lanes is always preserved.
- R2: Code i in 0..23 selects the i-th entry, in lexicographic order, of the tuple (src0, src1, src2, src3), where output j equals input src_j. Code 1 gives (0,1,3,2), code 6 gives (1,0,2,3) and code 23 gives (3,2,1,0).
- R3: Code 0 is the identity: output j equals input j.
- R4: Codes 24 to 31 give no new routing. Each of them behaves exactly as the identity.
- R5: Stage k (counting from 1) uses challenge bits [(k-1)*5 +: 5]. Stage 1 is fed from path_in, stage k is fed from the outputs of stage k-1, and path_out is the output of the last stage.
- R6: The chain is purely combinational. path_out follows a change on path_in or challenge with no clock edge in between.
- R7: When all four lane inputs carry the same value, all four outputs carry that value, whatever the challenge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| path_in | input | 4 | Lane values entering stage 1 (bit j is lane j) |
| challenge | input | 5*N_STAGES | One 5-bit routing code per stage; stage 1 uses the lowest slice |
| path_out | output | 4 | Lane values leaving the last stage |

## Verification
The bench builds two instances of the chain. The first has N_STAGES = 1. This isolates a single stage, so all 32 codes can be checked against the expected ordering with every one-hot lane pattern and both uniform patterns. That covers the full lexicographic table and the folded codes 24 to 31. The second has N_STAGES = 3. Placing different codes in each slice shows that stages compose in the order of their slices, which a single stage cannot show.

// File: rtl/perm_pkg.sv
// perm_pkg: shared widths, select types and the code-to-ordering
// function for the four-lane switch chain.
// Assumes four lanes and a 5-bit code; codes past the last ordering
// decode to the identity.
package perm_pkg;
    localparam int LANES   = 4;
    localparam int CODE_W  = 5;
    localparam int SEL_W   = $clog2(LANES);
    localparam int N_PERMS = 24;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef sel_t [LANES-1:0]  sel_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    // Builds the source index of each output lane from a factorial-base split of the code
    function automatic sel_vec_t perm_of_code(input code_t code);
        sel_vec_t res;
        logic [LANES-1:0] used;
        int rem;
        int radix;
        int digit;
        int seen;
        used = '0;
        res  = '0;
        if (int'(code) >= N_PERMS) begin
            for (int j = 0; j < LANES; j++) res[j] = sel_t'(j);
        end else begin
            rem   = int'(code);
            radix = 6;
            for (int pos = 0; pos < LANES; pos++) begin
                digit = rem / radix;
                rem   = rem % radix;
                seen  = 0;
                for (int c = 0; c < LANES; c++) begin
                    if (!used[c]) begin
                        if (seen == digit) begin
                            res[pos] = sel_t'(c);
                            used[c]  = 1'b1;
                        end
                        seen = seen + 1;
                    end
                end
                if (radix > 1) radix = radix / (LANES - 1 - pos);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/perm_decoder.sv
// perm_decoder: turns one 5-bit routing code into four 2-bit lane selects.
// Assumes nothing about the code range; out-of-range codes give the identity.
module perm_decoder
    import perm_pkg::*;
(
    input  code_t    code,
    output sel_vec_t sels
);
    // Pure lookup of the ordering for this code
    always_comb begin
        sels = perm_of_code(code);
    end
endmodule

// File: rtl/perm_mux4.sv
// perm_mux4: one output lane, picking any of the four stage inputs.
// Assumes the select is a lane index 0..3.
module perm_mux4
    import perm_pkg::*;
(
    input  logic [LANES-1:0] din,
    input  sel_t             sel,
    output logic             dout
);
    // Route the chosen lane to the output
    always_comb begin
        dout = din[sel];
    end
endmodule

// File: rtl/perm_stage.sv
// perm_stage: one routing stage built from a code decoder and four muxes.
// Assumes every mux sees all four inputs; the decoder keeps selects distinct.
module perm_stage
    import perm_pkg::*;
(
    input  logic [LANES-1:0] lane_in,
    input  code_t            code,
    output logic [LANES-1:0] lane_out
);
    sel_vec_t sels;

    perm_decoder u_dec (
        .code (code),
        .sels (sels)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_mux
        perm_mux4 u_mux (
            .din  (lane_in),
            .sel  (sels[j]),
            .dout (lane_out[j])
        );
    end
endmodule

// File: rtl/perm_chain.sv
// perm_chain: N_STAGES routing stages in series, each with its own code slice.
// Assumes stage k (from 1) reads challenge[(k-1)*5 +: 5]; no clock, no state.
module perm_chain #(
    parameter int N_STAGES = 4
) (
    input  logic [3:0]            path_in,
    input  logic [5*N_STAGES-1:0] challenge,
    output logic [3:0]            path_out
);
    import perm_pkg::*;

    localparam int CH_W = CODE_W * N_STAGES;

    logic [LANES-1:0] lanes [N_STAGES+1];

    // Feed the first stage from the block inputs
    always_comb begin
        lanes[0] = path_in;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        perm_stage u_stage (
            .lane_in  (lanes[k]),
            .code     (challenge[k*CODE_W +: CODE_W]),
            .lane_out (lanes[k+1])
        );
    end

    // Last stage drives the block outputs
    always_comb begin
        path_out = lanes[N_STAGES];
    end

    if (CH_W != $bits(challenge)) begin : g_bad_width
        $error("challenge width mismatch");
    end
endmodule

// File: rtl/perm_chain_chk.sv
// perm_chain_chk: port-level properties of the switch chain, bound to perm_chain.
// Assumes only combinational behaviour; checks run once inputs are known.
module perm_chain_chk #(
    parameter int N_STAGES = 4
) (
    input logic [3:0]            path_in,
    input logic [5*N_STAGES-1:0] challenge,
    input logic [3:0]            path_out
);
    logic all_zero_code;
    logic all_folded;

    // Classify the challenge as all-identity slices or all-folded slices
    always_comb begin
        all_zero_code = 1'b1;
        all_folded    = 1'b1;
        for (int k = 0; k < N_STAGES; k++) begin
            if (challenge[k*5 +: 5] != 5'd0)  all_zero_code = 1'b0;
            if (challenge[k*5 +: 5] < 5'd24)  all_folded    = 1'b0;
        end
    end

    // Combinational properties checked whenever the inputs are known
    always_comb begin
        if (!$isunknown({path_in, challenge})) begin
            // R1
            lane_count_chk: assert ($countones(path_out) == $countones(path_in));
            // R1
            onehot_kept_chk: assert (!$onehot(path_in) || $onehot(path_out));
            // R3
            identity_chk: assert (!all_zero_code || (path_out == path_in));
            // R4
            folded_code_chk: assert (!all_folded || (path_out == path_in));
            // R7
            uniform_lanes_chk: assert (!((path_in == 4'h0) || (path_in == 4'hF))
                                       || (path_out == path_in));
        end
    end
endmodule

bind perm_chain perm_chain_chk #(.N_STAGES(N_STAGES)) u_chain_chk (
    .path_in   (path_in),
    .challenge (challenge),
    .path_out  (path_out)
);

// File: tb/perm_chain_bench.sv
// perm_chain_bench: table-driven check of single-stage routing, then directed
// tests of folded codes, uniform lanes and stage ordering on a 3-stage chain.
module perm_chain_bench;
    // Expected source tuple per code: nibbles from msb are src0, src1, src2, src3 (R2)
    localparam logic [15:0] PERM_TAB [24] = '{
        16'h0123, 16'h0132, 16'h0213, 16'h0231, 16'h0312, 16'h0321,
        16'h1023, 16'h1032, 16'h1203, 16'h1230, 16'h1302, 16'h1320,
        16'h2013, 16'h2031, 16'h2103, 16'h2130, 16'h2301, 16'h2310,
        16'h3012, 16'h3021, 16'h3102, 16'h3120, 16'h3201, 16'h3210
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [3:0]  in1, out1;
    logic [4:0]  ch1;
    logic [3:0]  in3, out3;
    logic [14:0] ch3;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    perm_chain #(.N_STAGES(1)) u_perm_chain (
        .path_in (in1), .challenge (ch1), .path_out (out1)
    );
    perm_chain #(.N_STAGES(3)) u_perm_chain_deep (
        .path_in (in3), .challenge (ch3), .path_out (out3)
    );

    // Expected output of one stage from the table; codes 24..31 are identity (R4)
    function automatic logic [3:0] route(input logic [4:0] code, input logic [3:0] din);
        logic [3:0] r;
        logic [15:0] t;
        if (code >= 5'd24) return din;
        t = PERM_TAB[code];
        for (int j = 0; j < 4; j++) r[j] = din[t[(3-j)*4 +: 2]];
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        in1 = '0; ch1 = '0; in3 = '0; ch3 = '0;
        @(negedge clk);
        #1;
        // R3 settled state with zero code
        check("R3 zero code, zero lanes", out1, 4'h0);

        // R2 R1 R4: every code with every one-hot lane pattern
        for (int c = 0; c < 32; c++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                ch1 = 5'(c);
                in1 = 4'b0001 << b;
                #1;
                if (c >= 24) check("R4 folded code", out1, in1);
                else if (c == 0) check("R3 identity", out1, in1);
                else check("R2 ordering", out1, route(5'(c), in1));
            end
        end

        // R3 identity with a mixed pattern
        @(negedge clk); ch1 = 5'd0; in1 = 4'b1010; #1;
        check("R3 identity mixed", out1, 4'b1010);

        // R2 code 23 reverses lanes
        @(negedge clk); ch1 = 5'd23; in1 = 4'b0011; #1;
        check("R2 reversal", out1, 4'b1100);

        // R7 uniform lanes under every code
        for (int c = 0; c < 32; c++) begin
            @(negedge clk); ch1 = 5'(c); in1 = 4'hF; #1;
            check("R7 all ones", out1, 4'hF);
            in1 = 4'h0; #1;
            check("R7 all zeros", out1, 4'h0);
        end

        // R6 output follows an input change with no clock edge
        @(negedge clk); ch1 = 5'd6; in1 = 4'b0001; #1;
        check("R6 before change", out1, 4'b0010);
        in1 = 4'b0100; #1;
        check("R6 after change no edge", out1, 4'b0100);

        // R5 slice order on the 3-stage chain
        for (int v = 0; v < 4; v++) begin
            logic [4:0] a, b2, c3;
            a  = 5'(1 + v * 5);
            b2 = 5'(6 + v * 3);
            c3 = 5'(23 - v * 2);
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                ch3 = {c3, b2, a};
                in3 = 4'b0001 << b;
                #1;
                check("R5 slice order", out3, route(c3, route(b2, route(a, in3))));
            end
        end

        // R5 swapped slices give the other composition
        @(negedge clk); ch3 = {5'd0, 5'd3, 5'd1}; in3 = 4'b0010; #1;
        check("R5 stage1 low slice", out3, route(5'd3, route(5'd1, 4'b0010)));
        @(negedge clk); ch3 = {5'd0, 5'd1, 5'd3}; in3 = 4'b0010; #1;
        check("R5 swapped slices", out3, route(5'd1, route(5'd3, 4'b0010)));

        // R4 all slices folded
        @(negedge clk); ch3 = {5'd31, 5'd24, 5'd27}; in3 = 4'b0110; #1;
        check("R4 folded chain", out3, 4'b0110);

        // R7 uniform stimulus through the chain
        @(negedge clk); ch3 = {5'd17, 5'd9, 5'd14}; in3 = 4'hF; #1;
        check("R7 chain broadcast", out3, 4'hF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule